// File: doc/BRIEF.md
# Local History Branch Direction Predictor

This block predicts whether a conditional branch will be taken, using only that branch's own recent outcomes. A direct-mapped history cache, selected by the low bits of the branch address and guarded by a partial tag, holds a short shift register of outcomes for each branch. That history forms the index into one array of 2-bit saturating counters. Every branch shares this array. The counter's upper bit is the prediction.

The fetch side presents an address and gets back a direction, a hit flag and the counter index it used. The resolution side returns the same address, the real outcome and that captured index. The counter at that index is moved one step toward the outcome. The branch's history either shifts in the outcome or, on a tag miss, is freshly allocated. A build-time mode picks how address bits join the history in the index: history alone, history with extra address bits appended, or history XOR address bits.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset every cache entry is invalid and every counter holds weak-taken (2'b10), so any address reads back predHit=0 and predTaken=1.
- R2: On a tag miss predHit is 0, predTaken is 1 and predIndex is formed from an all-zero history.
- R3: An update whose address misses writes that set with the address tag and a zero history. The next prediction for that address hits and sees history 0.
- R4: An update whose address hits shifts the outcome into history bit 0 (1 = taken) and drops bit HIST_W-1. With 6 history bits, a single taken outcome followed by six not-taken outcomes returns the history to 0.
- R5: An update steps the counter at updIndex (the index captured at prediction) up on taken, saturating at 2'b11, and down on not-taken, saturating at 2'b00.
- R6: On a hit, predTaken is bit 1 of the counter at predIndex.
- R7: The set is addr[5:0] and the tag is addr[13:6]. An address that matches the set but not the stored tag misses, and its update replaces the entry.
- R8: In history-only mode (MIX_MODE=0) predIndex equals the history.
- R9: In append mode (MIX_MODE=1) predIndex is {history, addr[7:6]}, with the history in the upper bits.
- R10: In XOR mode (MIX_MODE=2, the default) predIndex is history XOR addr[11:6].
- R11: Predictions read the state as it stood before any update in the same cycle. An update takes effect from the following cycle.
- R12: While updValid is low, no counter or cache entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predAddr | input | ADDR_W | Branch address looked up at fetch |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHit | output | 1 | History cache tag hit for predAddr |
| predIndex | output | IDX_W | Counter index used for this prediction |
| updValid | input | 1 | Resolution update strobe |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updIndex | input | IDX_W | Counter index captured at prediction |

## Verification
The bench drives a single branch through a history that walks one set bit from bit 0 to bit 5 and then out of the register. A design that keeps the oldest bit, or shifts the wrong way, produces the wrong index on the next vector. It drives the counter past both rails and checks that it saturates instead of wrapping, which would show up as a flipped prediction on the next lookup. A second address that shares the set but not the tag must miss and then evict the first. A design that compares too few tag bits would report a false hit instead. Three instances, one per index mode, run side by side, so a mis-ordered append or an XOR taken from the wrong address bits shows up directly as a wrong predIndex.

// File: rtl/lp_pkg.sv
package lp_pkg;

  localparam int MIX_HIST = 0;
  localparam int MIX_CAT  = 1;
  localparam int MIX_XOR  = 2;

  typedef enum logic [1:0] {
    CNT_STRONG_NT = 2'b00,
    CNT_WEAK_NT   = 2'b01,
    CNT_WEAK_T    = 2'b10,
    CNT_STRONG_T  = 2'b11
  } cnt_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntWrite;
    logic cntUp;
    logic histShift;
    logic histAlloc;
  } lp_strobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == CNT_STRONG_T) ? cur : cur + 2'd1;
    else    nxt = (cur == CNT_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/lp_index_mix.sv
module lp_index_mix #(
  parameter int ADDR_W   = 32,
  parameter int SET_W    = 6,
  parameter int HIST_W   = 6,
  parameter int CAT_W    = 2,
  parameter int MIX_MODE = 2,
  parameter int IDX_W    = 6
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  generate
    if (MIX_MODE == lp_pkg::MIX_CAT) begin : g_cat
      always_comb idx = {hist, addr[SET_W +: CAT_W]};
    end else if (MIX_MODE == lp_pkg::MIX_XOR) begin : g_xor
      always_comb idx = hist ^ addr[SET_W +: HIST_W];
    end else begin : g_hist
      always_comb idx = hist;
    end
  endgenerate
endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 64,
  parameter int TAG_W    = 8,
  parameter int HIST_W   = 6,
  parameter int CAT_W    = 2,
  parameter int MIX_MODE = 2,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] predAddr,
  output logic              predTaken,
  output logic              predHit,
  output logic [IDX_W-1:0]  predIndex,
  output logic [HIST_W-1:0] predHistory,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  logic [IDX_W-1:0]  updIndex,
  output logic              updHit,
  input  lp_strobe_t        strobe
);
  localparam int SET_W     = $clog2(SETS);
  localparam int CNT_DEPTH = 1 << IDX_W;

  logic              entryValid [SETS];
  logic [TAG_W-1:0]  entryTag   [SETS];
  logic [HIST_W-1:0] entryHist  [SETS];
  logic [1:0]        cntMem     [CNT_DEPTH];

  logic [SET_W-1:0]  predSet, updSet;
  logic [TAG_W-1:0]  predTag, updTag;

  // Fetch-side lookup
  always_comb begin
    predSet     = predAddr[SET_W-1:0];
    predTag     = predAddr[SET_W +: TAG_W];
    predHit     = entryValid[predSet] && (entryTag[predSet] == predTag);
    predHistory = predHit ? entryHist[predSet] : '0;
  end

  lp_index_mix #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .HIST_W(HIST_W),
    .CAT_W(CAT_W), .MIX_MODE(MIX_MODE), .IDX_W(IDX_W)
  ) u_mix (
    .hist(predHistory),
    .addr(predAddr),
    .idx (predIndex)
  );

  always_comb predTaken = predHit ? cntMem[predIndex][1] : 1'b1;

  // Resolution-side lookup
  always_comb begin
    updSet = updAddr[SET_W-1:0];
    updTag = updAddr[SET_W +: TAG_W];
    updHit = entryValid[updSet] && (entryTag[updSet] == updTag);
  end

  // History cache storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        entryValid[s] <= 1'b0;
        entryTag[s]   <= '0;
        entryHist[s]  <= '0;
      end
    end else if (strobe.histAlloc) begin
      entryValid[updSet] <= 1'b1;
      entryTag[updSet]   <= updTag;
      entryHist[updSet]  <= '0;
    end else if (strobe.histShift) begin
      entryHist[updSet] <= {entryHist[updSet][HIST_W-2:0], updTaken};
    end
  end

  // Shared counter array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < CNT_DEPTH; c++) cntMem[c] <= CNT_WEAK_T;
    end else if (strobe.cntWrite) begin
      cntMem[updIndex] <= satStep(cntMem[updIndex], strobe.cntUp);
    end
  end

endmodule

// File: rtl/lp_control.sv
module lp_control
  import lp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updHit,
  output lp_strobe_t strobe
);
  always_comb begin
    strobe.cntWrite  = updValid;
    strobe.cntUp     = updTaken;
    strobe.histShift = updValid && updHit;
    strobe.histAlloc = updValid && !updHit;
  end
endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor
  import lp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SETS     = 64,
  parameter int TAG_W    = 8,
  parameter int HIST_W   = 6,
  parameter int CAT_W    = 2,
  parameter int MIX_MODE = 2,
  parameter int IDX_W    = (MIX_MODE == 1) ? HIST_W + CAT_W : HIST_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] predAddr,
  output logic              predTaken,
  output logic              predHit,
  output logic [IDX_W-1:0]  predIndex,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  logic [IDX_W-1:0]  updIndex
);
  lp_strobe_t        ctl;
  logic              updHit;
  logic [HIST_W-1:0] predHistory;

  lp_control u_ctl (
    .updValid(updValid),
    .updTaken(updTaken),
    .updHit  (updHit),
    .strobe  (ctl)
  );

  lp_datapath #(
    .ADDR_W(ADDR_W), .SETS(SETS), .TAG_W(TAG_W), .HIST_W(HIST_W),
    .CAT_W(CAT_W), .MIX_MODE(MIX_MODE), .IDX_W(IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .predAddr   (predAddr),
    .predTaken  (predTaken),
    .predHit    (predHit),
    .predIndex  (predIndex),
    .predHistory(predHistory),
    .updAddr    (updAddr),
    .updTaken   (updTaken),
    .updIndex   (updIndex),
    .updHit     (updHit),
    .strobe     (ctl)
  );
endmodule

// File: rtl/lp_checker.sv
module lp_checker
  import lp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 6,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] predAddr,
  input logic              predTaken,
  input logic              predHit,
  input logic [IDX_W-1:0]  predIndex,
  input logic [HIST_W-1:0] predHistory,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken,
  input lp_strobe_t        ctl
);
  assert_miss_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> predTaken);

  assert_alloc_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && (predAddr == updAddr)) |=> ($stable(predAddr) -> predHit));

  assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && predHit && (predAddr == updAddr)) |=>
      ($stable(predAddr) ->
        (predHistory == {$past(predHistory[HIST_W-2:0]), $past(updTaken)})));

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> ($stable(predAddr) ->
      ($stable(predHit) && $stable(predTaken) && $stable(predIndex))));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.histShift, ctl.histAlloc}) && (ctl.cntWrite == updValid));
endmodule

bind local_hist_predictor lp_checker #(
  .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .predAddr   (predAddr),
  .predTaken  (predTaken),
  .predHit    (predHit),
  .predIndex  (predIndex),
  .predHistory(predHistory),
  .updValid   (updValid),
  .updAddr    (updAddr),
  .updTaken   (updTaken),
  .ctl        (ctl)
);

// File: tb/test_local_hist_predictor.sv
module test_local_hist_predictor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] predAddr = '0;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic        updTaken = 1'b0;
  logic [5:0]  updIdxX = '0, updIdxH = '0;
  logic [7:0]  updIdxC = '0;

  logic       takX, hitX, takH, hitH, takC, hitC;
  logic [5:0] idxX, idxH;
  logic [7:0] idxC;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  local_hist_predictor i_local_hist_predictor (
    .clk(clk), .rstN(rstN), .predAddr(predAddr),
    .predTaken(takX), .predHit(hitX), .predIndex(idxX),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken), .updIndex(updIdxX));

  local_hist_predictor #(.MIX_MODE(0)) iHist (
    .clk(clk), .rstN(rstN), .predAddr(predAddr),
    .predTaken(takH), .predHit(hitH), .predIndex(idxH),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken), .updIndex(updIdxH));

  local_hist_predictor #(.MIX_MODE(1)) iCat (
    .clk(clk), .rstN(rstN), .predAddr(predAddr),
    .predTaken(takC), .predHit(hitC), .predIndex(idxC),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken), .updIndex(updIdxC));

  typedef struct packed {
    logic [31:0] addr;
    logic        taken;
    logic        hit;
    logic        pred;
    logic [5:0]  hist;
  } vec_t;

  localparam logic [31:0] ADDR_A = 32'h0000_0481; // set 1, tag 0x12
  localparam logic [31:0] ADDR_B = 32'h0000_0C41; // set 1, tag 0x31

  localparam vec_t VECS [16] = '{
    '{ADDR_A, 1'b1, 1'b0, 1'b1, 6'd0},
    '{ADDR_A, 1'b1, 1'b1, 1'b1, 6'd0},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd1},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd2},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd4},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd8},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd16},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd32},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd0},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd0},
    '{ADDR_A, 1'b0, 1'b1, 1'b0, 6'd0},
    '{ADDR_A, 1'b0, 1'b1, 1'b0, 6'd0},
    '{ADDR_A, 1'b1, 1'b1, 1'b0, 6'd0},
    '{ADDR_A, 1'b1, 1'b1, 1'b0, 6'd1},
    '{ADDR_A, 1'b0, 1'b1, 1'b1, 6'd3},
    '{ADDR_A, 1'b1, 1'b1, 1'b1, 6'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Drive a lookup at the falling edge; optionally arm an update with the captured indices
  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    updValid = 1'b0;
    predAddr = a;
    #1;
  endtask

  task automatic arm_update(input logic [31:0] a, input logic t);
    updAddr  = a;
    updTaken = t;
    updIdxX  = idxX;
    updIdxH  = idxH;
    updIdxC  = idxC;
    updValid = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state on all modes
    foreach (VECS[k]) if (k < 3) begin
      lookup(k == 0 ? 32'h0 : (k == 1 ? ADDR_A : 32'hFFFF_FFFF));
      chk("R1 hit", {29'd0, hitX, hitH, hitC}, 32'd0);
      chk("R1 taken", {29'd0, takX, takH, takC}, 32'd7);
    end

    // R12: updates held off while updValid is low
    @(negedge clk);
    updAddr = ADDR_A; updTaken = 1'b1; updValid = 1'b0;
    repeat (3) @(posedge clk);
    lookup(ADDR_A);
    chk("R12 no alloc", {31'd0, hitX}, 32'd0);

    // Vector walk on one branch
    foreach (VECS[i]) begin
      lookup(VECS[i].addr);
      chk(VECS[i].hit ? "R3 hit" : "R2 miss", {31'd0, hitX}, {31'd0, VECS[i].hit});
      chk("R6 pred", {31'd0, takX}, {31'd0, VECS[i].pred});
      chk("R10 xor idx", {26'd0, idxX}, {26'd0, VECS[i].hist ^ VECS[i].addr[11:6]});
      chk("R8 hist idx", {26'd0, idxH}, {26'd0, VECS[i].hist});
      chk("R9 cat idx", {24'd0, idxC}, {24'd0, VECS[i].hist, VECS[i].addr[7:6]});
      chk("R4 hit other modes", {30'd0, hitH, hitC}, {30'd0, VECS[i].hit, VECS[i].hit});
      arm_update(VECS[i].addr, VECS[i].taken);
    end

    // R7: same set, different tag
    lookup(ADDR_B);
    chk("R7 miss", {31'd0, hitX}, 32'd0);
    chk("R2 miss taken", {31'd0, takX}, 32'd1);
    chk("R2 miss idx", {26'd0, idxX}, 32'd49);
    chk("R9 cat miss idx", {24'd0, idxC}, 32'd1);
    arm_update(ADDR_B, 1'b1);
    lookup(ADDR_A);
    chk("R7 evicted", {31'd0, hitX}, 32'd0);

    // R11: update and lookup in the same cycle
    lookup(ADDR_B);
    chk("R3 alloc hit", {31'd0, hitX}, 32'd1);
    arm_update(ADDR_B, 1'b1);
    #1;
    chk("R11 old idx", {26'd0, idxX}, 32'd49);
    lookup(ADDR_B);
    chk("R11 new idx", {26'd0, idxX}, 32'd48);
    chk("R5 fresh pred", {31'd0, takX}, 32'd1);

    @(negedge clk);
    finish_run();
  end

endmodule